// File: doc/BRIEF.md
# Masked Word Port to a 64-Byte Scratch RAM

This block gives a host a 32-bit word window onto a small scratch RAM of 64 bytes. The host presents a byte address, and the block subtracts a fixed base from it. Only the low six bits of the result select a location, so the window repeats every 64 bytes. The two lowest bits are then dropped to pick one of sixteen words. Inside, the RAM is organised as four byte lanes. The byte at the lowest address of a word travels in bits 31:24 of the bus.

A write does not simply replace a word. The block clears the old bits that the write mask selects, ORs the full write data into what remains, and stores that result. Every write also raises a one-cycle interrupt-set pulse.

Reads are registered, with one cycle of latency. Two word offsets behave specially on a read. A read of 0x3C returns an 8-bit status register, zero-extended, in place of RAM. A read of 0x24 returns RAM as usual and, as a side effect, sets that status register to 0x80.

Top module: `sp_host_port`

## Requirements
- R1: The word is selected by bits 5:2 of (address minus BASE). Address bits above bit 5 and the two lowest bits have no effect, so a misaligned address acts on the word that contains it.
- R2: Read data appears on `rdata` in the cycle after `rd_en` and then holds until the next read.
- R3: A read at word offset 0x3C returns {24'h0, status} instead of RAM contents.
- R4: A read at word offset 0x24 returns the stored word there. From the next cycle on, status equals 0x80.
- R5: A write stores (old & ~wmask) | wdata into the selected word. Data bits outside the mask are still ORed in.
- R6: `irq_set` is high for exactly the one cycle after each cycle in which `wr_en` is high, and is low otherwise.
- R7: After reset, `rdata`, `irq_set` and status are all zero. Status only ever takes the values 0x00 or 0x80.
- R8: A write to offset 0x3C updates RAM but leaves status unchanged, so a later read of 0x3C still returns status.
- R9: When a read and a write hit the same word in the same cycle, the read returns the content from before the write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | ADDR_W | Host byte address |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| wdata | input | 32 | Write data, ORed in after masking |
| wmask | input | 32 | Selects the old bits to clear |
| rdata | output | 32 | Registered read data |
| irq_set | output | 1 | One-cycle interrupt-set pulse per write |

## Verification
Read data and the interrupt pulse are both due one clock edge after the strobe. The status change caused by a read of 0x24 is visible to any read of 0x3C issued in a later cycle. The bench drives each strobe on a falling edge and compares outputs on the next falling edge, which comes right after the single register stage. Status is checked only through reads of 0x3C.

// File: rtl/sp_pkg.sv
package sp_pkg;
  localparam int DATA_W     = 32;
  localparam int BYTE_W     = 8;
  localparam int LANES      = DATA_W / BYTE_W;
  localparam int LANE_W     = $clog2(LANES);
  localparam int STAT_W     = 8;
  localparam logic [STAT_W-1:0] STAT_ARMED = 8'h80;
endpackage

// File: rtl/sp_lane_ram.sv
module sp_lane_ram #(
  parameter int DEPTH = 16,
  parameter int AW    = $clog2(DEPTH),
  parameter int W     = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] idx,
  input  logic [W-1:0]  wbyte,
  output logic [W-1:0]  rbyte
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[idx] <= wbyte;
  end

  assign rbyte = mem[idx];
endmodule

// File: rtl/sp_status.sv
module sp_status
  import sp_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              arm,
  output logic [STAT_W-1:0] status
);
  always_ff @(posedge clk) begin
    if (rst)      status <= '0;
    else if (arm) status <= STAT_ARMED;
  end

  // R7
  status_values_chk: assert property (@(posedge clk) disable iff (rst)
    (status == '0) || (status == STAT_ARMED));
endmodule

// File: rtl/sp_host_port.sv
module sp_host_port
  import sp_pkg::*;
#(
  parameter int              ADDR_W    = 32,
  parameter logic [31:0]     BASE      = 32'h1FC0_07C0,
  parameter int              RAM_BYTES = 64,
  parameter int              SEED_OFF  = 'h24,
  parameter int              STAT_OFF  = 'h3C
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              rd_en,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wdata,
  input  logic [DATA_W-1:0] wmask,
  output logic [DATA_W-1:0] rdata,
  output logic              irq_set
);
  localparam int WORDS     = RAM_BYTES / LANES;
  localparam int IDX_W     = $clog2(WORDS);
  localparam logic [IDX_W-1:0] SEED_IDX = IDX_W'(SEED_OFF / LANES);
  localparam logic [IDX_W-1:0] STAT_IDX = IDX_W'(STAT_OFF / LANES);

  logic [ADDR_W-1:0] rel;
  logic [IDX_W-1:0]  idx;
  logic [DATA_W-1:0] old_word;
  logic [DATA_W-1:0] new_word;
  logic [STAT_W-1:0] status;
  logic              arm;

  assign rel = addr - ADDR_W'(BASE);
  assign idx = IDX_W'(rel >> LANE_W);

  assign new_word = (old_word & ~wmask) | wdata;
  assign arm      = rd_en && (idx == SEED_IDX);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    sp_lane_ram #(.DEPTH(WORDS), .AW(IDX_W), .W(BYTE_W)) u_lane (
      .clk   (clk),
      .we    (wr_en),
      .idx   (idx),
      .wbyte (new_word[DATA_W-1-g*BYTE_W -: BYTE_W]),
      .rbyte (old_word[DATA_W-1-g*BYTE_W -: BYTE_W])
    );
  end

  sp_status u_status (
    .clk    (clk),
    .rst    (rst),
    .arm    (arm),
    .status (status)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata   <= '0;
      irq_set <= 1'b0;
    end else begin
      irq_set <= wr_en;
      if (rd_en) begin
        if (idx == STAT_IDX) rdata <= {{(DATA_W-STAT_W){1'b0}}, status};
        else                 rdata <= old_word;
      end
    end
  end

  // R6
  irq_follow_chk: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> irq_set);
  // R6
  irq_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> !irq_set);
  // R2
  rdata_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rdata));
  // R4
  seed_arms_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_en && idx == SEED_IDX) |=> (status == STAT_ARMED));
  // R3
  stat_read_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_en && idx == STAT_IDX) |=> (rdata[DATA_W-1:STAT_W] == '0));
endmodule

// File: tb/sim_sp_host_port.sv
module sim_sp_host_port;
  localparam logic [31:0] BASE = 32'h1FC0_07C0;

  logic        clk = 0;
  logic        rst = 1;
  logic [31:0] addr = '0;
  logic        rd_en = 0, wr_en = 0;
  logic [31:0] wdata = '0, wmask = '0;
  logic [31:0] rdata;
  logic        irq_set;

  int n_cmp = 0, n_bad = 0;
  logic [31:0] mdl [16];
  logic [7:0]  mstat;

  always #2 clk = ~clk;

  sp_host_port #(.BASE(BASE)) u0 (
    .clk(clk), .rst(rst), .addr(addr), .rd_en(rd_en), .wr_en(wr_en),
    .wdata(wdata), .wmask(wmask), .rdata(rdata), .irq_set(irq_set)
  );

  function automatic logic [31:0] merge(logic [31:0] o, logic [31:0] d, logic [31:0] m);
    return (o & ~m) | d;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(string req, logic [31:0] a, logic [31:0] d, logic [31:0] m);
    logic [3:0] i = 4'((a - BASE) >> 2);
    addr = a; wdata = d; wmask = m; wr_en = 1;
    @(negedge clk);
    wr_en = 0;
    mdl[i] = merge(mdl[i], d, m);
    chk(req, {31'b0, irq_set}, 32'd1);
    @(negedge clk);
    chk("R6", {31'b0, irq_set}, 32'd0);
  endtask

  task automatic rd(string req, logic [31:0] a);
    logic [3:0] i = 4'((a - BASE) >> 2);
    logic [31:0] e = (i == 4'hF) ? {24'b0, mstat} : mdl[i];
    addr = a; rd_en = 1;
    @(negedge clk);
    rd_en = 0;
    if (i == 4'h9) mstat = 8'h80;
    chk(req, rdata, e);
    addr = $urandom; 
    @(negedge clk);
    chk("R2", rdata, e);
  endtask

  initial begin
    #100000;
    n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    mstat = 8'h00;
    repeat (3) @(negedge clk);
    rst = 0;
    // R7 reset state
    chk("R7 rdata", rdata, 32'h0);
    chk("R7 irq", {31'b0, irq_set}, 32'h0);
    for (int k = 0; k < 16; k++) begin
      mdl[k] = 32'h0;
      wr("R6", BASE + 32'(k*4), 32'h0, 32'hFFFF_FFFF);
    end
    rd("R7 status", BASE + 32'h3C);
    // R5 directed merge
    wr("R6", BASE + 32'h10, 32'hA5A5_0F0F, 32'hFFFF_FFFF);
    wr("R6", BASE + 32'h10, 32'h0000_0030, 32'h0000_00FF);
    rd("R5 merge", BASE + 32'h10);
    wr("R6", BASE + 32'h10, 32'h0100_0000, 32'h0000_0000);
    rd("R5 or-outside-mask", BASE + 32'h10);
    // R1 wrap and misalignment
    wr("R6", BASE + 32'h40 + 32'h14 + 32'h3, 32'hDEAD_BEEF, 32'hFFFF_FFFF);
    rd("R1 alias", BASE + 32'h14);
    rd("R1 misaligned", BASE + 32'hC0 + 32'h16);
    // R8 write at status offset
    wr("R6", BASE + 32'h3C, 32'h1234_5678, 32'hFFFF_FFFF);
    rd("R8 status kept", BASE + 32'h3C);
    // R4 seed read arms status
    wr("R6", BASE + 32'h24, 32'h000A_DD3F, 32'hFFFF_FFFF);
    rd("R4 seed data", BASE + 32'h24);
    rd("R4 R3 armed", BASE + 32'h3C);
    // R9 simultaneous read and write
    addr = BASE + 32'h08; rd_en = 1; wr_en = 1;
    wdata = 32'h5555_AAAA; wmask = 32'hFFFF_FFFF;
    @(negedge clk);
    rd_en = 0; wr_en = 0;
    chk("R9 old data", rdata, mdl[2]);
    chk("R6", {31'b0, irq_set}, 32'd1);
    mdl[2] = merge(mdl[2], 32'h5555_AAAA, 32'hFFFF_FFFF);
    @(negedge clk);
    rd("R9 new data", BASE + 32'h08);
    // R5 R3 random mix
    for (int n = 0; n < 300; n++) begin
      logic [31:0] a = BASE + ($urandom & 32'hFF);
      if ($urandom % 2) wr("R6", a, $urandom & $urandom, $urandom);
      else rd("R5 R3 random", a);
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule